// File: doc/BRIEF.md
# Elevator Car Sequencer

This block moves an elevator car between floors and runs its door. It is a four-state machine (idle, travelling up, travelling down, door cycle) that looks at two request vectors supplied by separate capture logic: one bit per floor for requests that should be served while rising, and one bit per floor for requests to be served while descending. It counts floor-position pulses to track where the car is, remembers which direction it last travelled, and drives three actuators: an up motor, a down motor and a door motor, the last with separate open and close commands.

Stops are qualified by direction. A rising car halts only at floors whose up bit is set, and a falling car only at floors whose down bit is set. At each stop the block pulses a one-cycle clear strobe for the exact bit it served, so the capture logic can drop it. The door is opened until the open sensor confirms, held for a fixed number of clock cycles, kept open while the doorway is blocked, then closed until the sensor reports it shut. The car then keeps going the same way if work remains ahead of it, and otherwise rests.

After reset the floor position is unknown, so the car first descends until the ground-floor limit switch closes and only then accepts requests.

Top module: `elev_ctrl`

## Requirements
- R1: While reset is held and afterwards until the ground limit switch is sampled high, the state is Down (10), the down motor is on and the floor output is 0; position pulses in this homing phase leave the floor at 0; the sample of the limit switch moves the state to Idle (00) with both motors off.
- R2: The state output uses Idle=00, Up=01, Down=10, Door=11; the up motor is on exactly in Up and the down motor exactly in Down.
- R3: In Idle the up vector is examined first: an up bit at the current floor starts a door cycle, else an up bit above the floor starts Up; only if neither holds, a down bit at the floor starts a door cycle, else a down bit below the floor starts Down.
- R4: Each position pulse sampled in Up adds one to the floor output, and each one sampled in Down (after homing) subtracts one.
- R5: A pulse in Up enters Door only if the up bit of the floor just reached is set; a pulse in Down enters Door only if the down bit of that floor is set; bits of the other vector never stop the car.
- R6: On the first cycle of each door cycle exactly one clear bit is high for one cycle: bit F of the up-clear vector when the stop served up bit F, or bit F of the down-clear vector when it served down bit F.
- R7: The open command is high from the first Door cycle until the open sensor is sampled high; the door then stays with both door commands low for exactly HOLD_TICKS cycles (540 by default) when the doorway is clear.
- R8: Once the hold time has run out, the close command stays low for as long as the blocked sensor is sampled high, and rises on the cycle after it is first sampled low.
- R9: The close command stays high until the open sensor is sampled low; the car then goes to Up if the last direction was up and an up bit lies above the floor, to Down if it was down and a down bit lies below, and to Idle otherwise.
- R10: The car never passes from Up to Down or from Down to Up directly; a pulse in Up reaching a floor with no up bit at or above it (or in Down with no down bit at or below it) moves the state to Idle.
- R11: The up and down motors are never on together, and neither travel motor is on while the door open or close command is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_up_i | input | NUM_FLOORS | Requests served while rising, one bit per floor |
| pend_dn_i | input | NUM_FLOORS | Requests served while descending, one bit per floor |
| gnd_limit_i | input | 1 | Ground-floor limit switch |
| floor_pulse_i | input | 1 | One-cycle pulse as the car reaches a floor |
| door_is_open_i | input | 1 | Door sensor, high when fully open |
| door_blocked_i | input | 1 | High while the doorway is obstructed |
| mot_up_o | output | 1 | Up travel motor |
| mot_dn_o | output | 1 | Down travel motor |
| door_open_o | output | 1 | Drive door motor towards open |
| door_close_o | output | 1 | Drive door motor towards closed |
| state_o | output | 2 | Current state code |
| dir_up_o | output | 1 | Last travel direction, 1 for up |
| floor_o | output | $clog2(NUM_FLOORS) | Current floor |
| clr_up_o | output | NUM_FLOORS | One-cycle clear for the served up bit |
| clr_dn_o | output | NUM_FLOORS | One-cycle clear for the served down bit |

## Verification
The hardest case to reach from the ports is a request vanishing while the car is already moving towards it, since the clear strobes normally remove bits only at a stop; the bench plays the request-capture logic itself, so it can withdraw the up bit in mid-travel and show the car stopping at the next floor in Idle without reversing. Direction qualification needs requests in both vectors at once on the same path, so a down bit is placed below an up target to show the rising car passes it and only returns for it afterwards. Around these, a sweep over every ordered pair of distinct floors on an eight-floor car checks position, stop floor, clear strobe and door timing arithmetically against a modelled shaft and door.

// File: rtl/elev_pkg.sv
package elev_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_UP   = 2'b01,
        ST_DOWN = 2'b10,
        ST_DOOR = 2'b11
    } car_state_e;

    typedef enum logic [1:0] {
        DP_REST,
        DP_OPEN,
        DP_HOLD,
        DP_CLOSE
    } door_phase_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic zero;
    } floor_step_t;

    localparam int unsigned MAX_FLOORS = 32;

    // Bits strictly above floor fl.
    function automatic logic [MAX_FLOORS-1:0] mask_above(input int unsigned fl);
        return ~((MAX_FLOORS'(2) << fl) - MAX_FLOORS'(1));
    endfunction

    // Bits strictly below floor fl.
    function automatic logic [MAX_FLOORS-1:0] mask_below(input int unsigned fl);
        return (MAX_FLOORS'(1) << fl) - MAX_FLOORS'(1);
    endfunction

endpackage

// File: rtl/elev_floor_ctr.sv
module elev_floor_ctr
    import elev_pkg::*;
#(
    parameter int NUM_FLOORS = 8,
    localparam int FW = (NUM_FLOORS > 1) ? $clog2(NUM_FLOORS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  floor_step_t   step_i,
    output logic [FW-1:0] floor_o
);

    localparam logic [FW-1:0] TOP = FW'(NUM_FLOORS - 1);

    logic [FW-1:0] floor_q;

    always_ff @(posedge clk) begin
        if (rst || step_i.zero) begin
            floor_q <= '0;
        end else if (step_i.up && floor_q != TOP) begin
            floor_q <= floor_q + FW'(1);
        end else if (step_i.dn && floor_q != '0) begin
            floor_q <= floor_q - FW'(1);
        end
    end

    assign floor_o = floor_q;

    // R4: the floor moves by one step only, and only when commanded
    p_floor_step_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(floor_q) |->
            (($past(step_i.up) && floor_q == $past(floor_q) + FW'(1)) ||
             ($past(step_i.dn) && floor_q == $past(floor_q) - FW'(1)) ||
             ($past(step_i.zero) && floor_q == '0)));

endmodule

// File: rtl/elev_door_seq.sv
module elev_door_seq
    import elev_pkg::*;
#(
    parameter int HOLD_TICKS = 540,
    localparam int TW = $clog2(HOLD_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic is_open_i,
    input  logic blocked_i,
    output logic open_cmd_o,
    output logic close_cmd_o,
    output logic done_o
);

    door_phase_e   ph_q;
    logic [TW-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= DP_REST;
            tmr_q <= '0;
        end else begin
            unique case (ph_q)
                DP_REST:  if (start_i) ph_q <= DP_OPEN;
                DP_OPEN: begin
                    if (is_open_i) begin
                        ph_q  <= DP_HOLD;
                        tmr_q <= TW'(HOLD_TICKS - 1);
                    end
                end
                DP_HOLD: begin
                    if (tmr_q != '0) begin
                        tmr_q <= tmr_q - TW'(1);
                    end else if (!blocked_i) begin
                        ph_q <= DP_CLOSE;
                    end
                end
                DP_CLOSE: if (!is_open_i) ph_q <= DP_REST;
                default:  ph_q <= DP_REST;
            endcase
        end
    end

    assign open_cmd_o  = (ph_q == DP_OPEN);
    assign close_cmd_o = (ph_q == DP_CLOSE);
    assign done_o      = (ph_q == DP_CLOSE) && !is_open_i;

    // R8: a blocked doorway keeps the door from starting to close
    p_blocked_defer_r8: assert property (@(posedge clk) disable iff (rst)
        (ph_q == DP_HOLD && blocked_i) |=> (ph_q != DP_CLOSE));

    // R7: the hold phase cannot end early while time remains
    p_hold_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (ph_q == DP_HOLD && tmr_q != '0) |=> (ph_q == DP_HOLD));

    // R9: closing continues until the sensor reports the door shut
    p_close_until_shut_r9: assert property (@(posedge clk) disable iff (rst)
        (ph_q == DP_CLOSE && is_open_i) |=> close_cmd_o);

endmodule

// File: rtl/elev_ctrl.sv
module elev_ctrl
    import elev_pkg::*;
#(
    parameter int NUM_FLOORS = 8,
    parameter int HOLD_TICKS = 540,
    localparam int FW = (NUM_FLOORS > 1) ? $clog2(NUM_FLOORS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_FLOORS-1:0] pend_up_i,
    input  logic [NUM_FLOORS-1:0] pend_dn_i,
    input  logic                  gnd_limit_i,
    input  logic                  floor_pulse_i,
    input  logic                  door_is_open_i,
    input  logic                  door_blocked_i,
    output logic                  mot_up_o,
    output logic                  mot_dn_o,
    output logic                  door_open_o,
    output logic                  door_close_o,
    output logic [1:0]            state_o,
    output logic                  dir_up_o,
    output logic [FW-1:0]         floor_o,
    output logic [NUM_FLOORS-1:0] clr_up_o,
    output logic [NUM_FLOORS-1:0] clr_dn_o
);

    localparam logic [FW-1:0] TOP = FW'(NUM_FLOORS - 1);

    car_state_e            st_q, st_d;
    logic                  dir_q, dir_d;
    logic                  homing_q;
    logic [NUM_FLOORS-1:0] clr_up_q, clr_dn_q;
    logic [FW-1:0]         floor_q, nf_up, nf_dn, tgt;
    logic                  go_door, tgt_up, door_done;
    floor_step_t           step;
    logic [MAX_FLOORS-1:0] up_ext, dn_ext;

    assign up_ext = MAX_FLOORS'(pend_up_i);
    assign dn_ext = MAX_FLOORS'(pend_dn_i);
    assign nf_up  = (floor_q == TOP) ? floor_q : floor_q + FW'(1);
    assign nf_dn  = (floor_q == '0)  ? floor_q : floor_q - FW'(1);

    elev_floor_ctr #(.NUM_FLOORS(NUM_FLOORS)) i_floor (
        .clk     (clk),
        .rst     (rst),
        .step_i  (step),
        .floor_o (floor_q)
    );

    elev_door_seq #(.HOLD_TICKS(HOLD_TICKS)) i_door (
        .clk         (clk),
        .rst         (rst),
        .start_i     (go_door),
        .is_open_i   (door_is_open_i),
        .blocked_i   (door_blocked_i),
        .open_cmd_o  (door_open_o),
        .close_cmd_o (door_close_o),
        .done_o      (door_done)
    );

    always_comb begin
        st_d    = st_q;
        dir_d   = dir_q;
        go_door = 1'b0;
        tgt     = floor_q;
        tgt_up  = dir_q;
        step    = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (pend_up_i[floor_q]) begin
                    go_door = 1'b1;
                    dir_d   = 1'b1;
                    tgt_up  = 1'b1;
                end else if (|(up_ext & mask_above(32'(floor_q)))) begin
                    st_d  = ST_UP;
                    dir_d = 1'b1;
                end else if (pend_dn_i[floor_q]) begin
                    go_door = 1'b1;
                    dir_d   = 1'b0;
                    tgt_up  = 1'b0;
                end else if (|(dn_ext & mask_below(32'(floor_q)))) begin
                    st_d  = ST_DOWN;
                    dir_d = 1'b0;
                end
            end
            ST_UP: begin
                if (floor_pulse_i) begin
                    step.up = 1'b1;
                    if (pend_up_i[nf_up]) begin
                        go_door = 1'b1;
                        tgt     = nf_up;
                        tgt_up  = 1'b1;
                    end else if (!(|(up_ext & mask_above(32'(nf_up))))) begin
                        st_d = ST_IDLE;
                    end
                end
            end
            ST_DOWN: begin
                if (homing_q) begin
                    if (gnd_limit_i) begin
                        step.zero = 1'b1;
                        st_d      = ST_IDLE;
                    end
                end else if (floor_pulse_i) begin
                    step.dn = 1'b1;
                    if (pend_dn_i[nf_dn]) begin
                        go_door = 1'b1;
                        tgt     = nf_dn;
                        tgt_up  = 1'b0;
                    end else if (!(|(dn_ext & mask_below(32'(nf_dn))))) begin
                        st_d = ST_IDLE;
                    end
                end
            end
            ST_DOOR: begin
                if (door_done) begin
                    if (dir_q && |(up_ext & mask_above(32'(floor_q))))
                        st_d = ST_UP;
                    else if (!dir_q && |(dn_ext & mask_below(32'(floor_q))))
                        st_d = ST_DOWN;
                    else
                        st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
        if (go_door) st_d = ST_DOOR;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_DOWN;
            dir_q    <= 1'b0;
            homing_q <= 1'b1;
            clr_up_q <= '0;
            clr_dn_q <= '0;
        end else begin
            st_q     <= st_d;
            dir_q    <= dir_d;
            if (step.zero) homing_q <= 1'b0;
            clr_up_q <= (go_door &&  tgt_up) ? (NUM_FLOORS'(1) << tgt) : '0;
            clr_dn_q <= (go_door && !tgt_up) ? (NUM_FLOORS'(1) << tgt) : '0;
        end
    end

    assign mot_up_o = (st_q == ST_UP);
    assign mot_dn_o = (st_q == ST_DOWN);
    assign state_o  = st_q;
    assign dir_up_o = dir_q;
    assign floor_o  = floor_q;
    assign clr_up_o = clr_up_q;
    assign clr_dn_o = clr_dn_q;

    // R1: homing drives down and holds the floor at zero
    p_homing_r1: assert property (@(posedge clk) disable iff (rst)
        homing_q |-> (mot_dn_o && floor_o == '0));

    // R5: a pulse without a matching up bit never stops a rising car
    p_up_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_UP && floor_pulse_i && !pend_up_i[nf_up]) |=> (st_q != ST_DOOR));

    // R5: a pulse without a matching down bit never stops a falling car
    p_dn_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DOWN && !homing_q && floor_pulse_i && !pend_dn_i[nf_dn])
            |=> (st_q != ST_DOOR));

    // R6: clear strobes are single, one-hot and tied to the door cycle
    p_clr_in_door_r6: assert property (@(posedge clk) disable iff (rst)
        (|{clr_up_o, clr_dn_o}) |-> (st_q == ST_DOOR && $onehot({clr_up_o, clr_dn_o})));

    // R10: no direct reversal
    p_no_reverse_up_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_UP) |=> (st_q != ST_DOWN));
    p_no_reverse_dn_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DOWN) |=> (st_q != ST_UP));

    // R11: travel motors and door motor are interlocked
    p_motor_interlock_r11: assert property (@(posedge clk) disable iff (rst)
        (door_open_o || door_close_o) |-> (!mot_up_o && !mot_dn_o));

endmodule

// File: tb/test_elev_ctrl.sv
`timescale 1ns/1ps
module test_elev_ctrl;

    localparam int NF     = 8;
    localparam int FW     = 3;
    localparam int HOLD   = 540;
    localparam int TRAVEL = 5;
    localparam int DLAT   = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst;
    logic [NF-1:0] pend_up, pend_dn;
    logic          gnd, floor_pulse, door_is_open, door_blocked;
    logic          mot_up, mot_dn, door_open, door_close, dir_up;
    logic [1:0]    state;
    logic [FW-1:0] floor_w;
    logic [NF-1:0] clr_up, clr_dn;

    elev_ctrl #(.NUM_FLOORS(NF), .HOLD_TICKS(HOLD)) i_elev_ctrl (
        .clk            (clk),
        .rst            (rst),
        .pend_up_i      (pend_up),
        .pend_dn_i      (pend_dn),
        .gnd_limit_i    (gnd),
        .floor_pulse_i  (floor_pulse),
        .door_is_open_i (door_is_open),
        .door_blocked_i (door_blocked),
        .mot_up_o       (mot_up),
        .mot_dn_o       (mot_dn),
        .door_open_o    (door_open),
        .door_close_o   (door_close),
        .state_o        (state),
        .dir_up_o       (dir_up),
        .floor_o        (floor_w),
        .clr_up_o       (clr_up),
        .clr_dn_o       (clr_dn)
    );

    int checks = 0;
    int errors = 0;
    int phys, tcnt, olat, clat;
    int hold_cnt, open_cnt, close_cnt, blk_release_at;
    int clr_events, last_clr_floor, clr_idx, exit_idx;
    logic last_clr_up;
    int clr_log [4];
    int exit_log [4];
    logic [1:0] prev_state;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    // One clock; sample outputs away from the edge and model shaft, door and request capture.
    task automatic cyc();
        @(posedge clk);
        #1;
        if (!rst) begin
            chk(!(mot_up && mot_dn) && !((mot_up || mot_dn) && (door_open || door_close)),
                "R11", int'({mot_up, mot_dn, door_open, door_close}), 0);
            chk(mot_up == (state == 2'b01) && mot_dn == (state == 2'b10),
                "R2", int'({mot_up, mot_dn}), int'(state));
        end
        if (|clr_up || |clr_dn) begin
            chk($onehot({clr_up, clr_dn}) && state == 2'b11, "R6",
                int'($countones({clr_up, clr_dn})), 1);
            for (int i = 0; i < NF; i++) if (clr_up[i] || clr_dn[i]) last_clr_floor = i;
            last_clr_up = |clr_up;
            clr_log[clr_idx % 4] = last_clr_floor;
            clr_idx++;
            clr_events++;
            pend_up = pend_up & ~clr_up;
            pend_dn = pend_dn & ~clr_dn;
            hold_cnt = 0; open_cnt = 0; close_cnt = 0;
        end
        if (prev_state == 2'b11 && state != 2'b11) begin
            exit_log[exit_idx % 4] = int'(state);
            exit_idx++;
        end
        prev_state = state;
        if (state == 2'b11 && !door_open && !door_close) hold_cnt++;
        if (door_open) open_cnt++;
        if (door_close) close_cnt++;
        if (door_open) begin
            olat++;
            if (olat >= DLAT) door_is_open = 1'b1;
        end else olat = 0;
        if (door_close) begin
            clat++;
            if (clat >= DLAT) door_is_open = 1'b0;
        end else clat = 0;
        if (blk_release_at > 0 && hold_cnt == blk_release_at) door_blocked = 1'b0;
        floor_pulse = 1'b0;
        if (mot_up || mot_dn) begin
            tcnt++;
            if (tcnt == TRAVEL) begin
                tcnt = 0;
                phys = mot_up ? phys + 1 : phys - 1;
                floor_pulse = 1'b1;
            end
        end else tcnt = 0;
        gnd = (phys == 0);
    endtask

    task automatic wait_idle(input string req);
        int guard = 0;
        while (!(state == 2'b00 && pend_up == '0 && pend_dn == '0 && !door_is_open)
               && guard < 20000) begin
            cyc();
            guard++;
        end
        chk(guard < 20000, req, guard, 20000);
    endtask

    // Place a request for floor t and check the whole trip.
    task automatic serve(input int t);
        int cur = int'(floor_w);
        int e0  = clr_events;
        bit up  = (t >= cur);
        if (up) pend_up[t] = 1'b1; else pend_dn[t] = 1'b1;
        wait_idle("R9");
        chk(int'(floor_w) == t, "R4", int'(floor_w), t);
        chk(phys == t, "R4", phys, t);
        chk(clr_events == e0 + 1, "R5", clr_events - e0, 1);
        chk(last_clr_floor == t && last_clr_up == up, "R6", last_clr_floor, t);
        chk(hold_cnt == HOLD, "R7", hold_cnt, HOLD);
        chk(open_cnt == DLAT, "R7", open_cnt, DLAT);
        chk(close_cnt == DLAT, "R9", close_cnt, DLAT);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog R9 actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int guard;
        int e0;
        bit floor_ok;
        rst = 1'b1;
        pend_up = '0; pend_dn = '0;
        phys = 3; tcnt = 0; olat = 0; clat = 0;
        gnd = 1'b0; floor_pulse = 1'b0; door_is_open = 1'b0; door_blocked = 1'b0;
        hold_cnt = 0; open_cnt = 0; close_cnt = 0; blk_release_at = 0;
        clr_events = 0; last_clr_floor = 0; last_clr_up = 1'b0; clr_idx = 0; exit_idx = 0;
        prev_state = 2'b00;
        for (int i = 0; i < 4; i++) begin clr_log[i] = -1; exit_log[i] = -1; end
        repeat (3) cyc();
        // R1: reset state
        chk(state == 2'b10, "R1", int'(state), 2);
        chk(mot_dn && !mot_up, "R1", int'({mot_up, mot_dn}), 1);
        chk(floor_w == '0, "R1", int'(floor_w), 0);
        rst = 1'b0;
        prev_state = state;
        guard = 0; floor_ok = 1'b1;
        while (state != 2'b00 && guard < 200) begin
            cyc();
            if (floor_w != '0) floor_ok = 1'b0;
            guard++;
        end
        chk(floor_ok, "R1", 1, 0);
        chk(state == 2'b00 && !mot_dn && !mot_up, "R1", int'(state), 0);
        chk(phys == 0, "R1", phys, 0);

        // R3: up bit at the current floor opens the door
        serve(0);
        // R3: down bit at the current floor, no up bits
        pend_dn[0] = 1'b1;
        wait_idle("R3");
        chk(last_clr_floor == 0 && !last_clr_up, "R3", int'(last_clr_up), 0);

        // R5: rising car passes a down request and serves it afterwards
        clr_idx = 0; exit_idx = 0;
        pend_up[6] = 1'b1; pend_dn[3] = 1'b1;
        wait_idle("R5");
        chk(clr_log[0] == 6, "R5", clr_log[0], 6);
        chk(clr_log[1] == 3, "R5", clr_log[1], 3);
        chk(exit_log[0] == 0, "R10", exit_log[0], 0);
        chk(int'(floor_w) == 3, "R4", int'(floor_w), 3);

        // R3: up requests take priority over down requests from Idle
        clr_idx = 0;
        pend_up[5] = 1'b1; pend_dn[1] = 1'b1;
        cyc();
        chk(state == 2'b01, "R3", int'(state), 1);
        wait_idle("R3");
        chk(clr_log[0] == 5 && clr_log[1] == 1, "R3", clr_log[0], 5);
        chk(int'(floor_w) == 1, "R4", int'(floor_w), 1);

        // R9: continue upward after a stop while up work remains
        exit_idx = 0;
        pend_up[2] = 1'b1; pend_up[5] = 1'b1;
        wait_idle("R9");
        chk(exit_log[0] == 1, "R9", exit_log[0], 1);
        chk(exit_log[1] == 0, "R9", exit_log[1], 0);
        chk(int'(floor_w) == 5, "R9", int'(floor_w), 5);
        // R9: continue downward
        exit_idx = 0;
        pend_dn[3] = 1'b1; pend_dn[0] = 1'b1;
        wait_idle("R9");
        chk(exit_log[0] == 2, "R9", exit_log[0], 2);
        chk(int'(floor_w) == 0, "R9", int'(floor_w), 0);

        // R10: request withdrawn in mid-travel, car rests instead of reversing
        e0 = clr_events;
        pend_up[6] = 1'b1;
        guard = 0;
        while (floor_w != 3'd2 && guard < 200) begin cyc(); guard++; end
        pend_up = '0;
        guard = 0;
        while (state == 2'b01 && guard < 200) begin cyc(); guard++; end
        chk(state == 2'b00, "R10", int'(state), 0);
        chk(int'(floor_w) == 3 && phys == 3, "R10", int'(floor_w), 3);
        repeat (20) cyc();
        chk(state == 2'b00 && phys == 3 && clr_events == e0, "R10", phys, 3);

        // R8: blocked doorway defers the close
        door_blocked = 1'b1; blk_release_at = 600;
        pend_dn[3] = 1'b1;
        wait_idle("R8");
        chk(hold_cnt == 600, "R8", hold_cnt, 600);
        chk(close_cnt == DLAT, "R8", close_cnt, DLAT);
        blk_release_at = 0;

        // R4/R5/R6/R7: every ordered pair of distinct floors
        for (int s = 0; s < NF; s++) begin
            for (int t = 0; t < NF; t++) begin
                if (s != t) begin
                    if (int'(floor_w) != s) serve(s);
                    serve(t);
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule